// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Fault Capture

This block holds recently used page translations for 8 KB pages. It stores them in four ways of sixteen entries each. One lookup finishes in one clock cycle and gives a hit with a page frame number and permissions. If the lookup fails, it gives a fault vector instead. Software fills entries through a plain write port, one way/index slot at a time. A lookup may fail because no way matches or because a protection check fails. On either kind of fault the block captures the details in a select register and a cause register, so a refill handler knows which slot to load. A 16-bit LFSR picks the way used for a refill, and it advances only on faults.

A chip uses two copies of this block. The copy with parameter `IS_INSN=1` serves instruction fetches and uses vector base 4. The copy with `IS_INSN=0` serves data accesses and uses vector base 8. Lookups enter through a valid/ready request channel and leave through a valid/ready result channel. The block holds one result in its result register. `lk_ready` is high when that register is empty or when the result is being taken in the same cycle. While `res_valid` is high and `res_ready` is low, the result stays unchanged and no new lookup is accepted. The select register, the cause register and the LFSR change only in a cycle in which a lookup is accepted.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, `res_valid` is 0, `tlb_sel` is 0, `mm_cause` is 0 and the LFSR holds 0xCCCC.
- R2: A write stores an entry at way `wr_way`, index `wr_idx`, and a lookup in the next cycle sees it. In `wr_hi`, bits [31:13] are the VPN and bits [7:0] are the PID. In `wr_lo`, bits [31:13] are the PFN, bit 4 is global, bit 3 valid, bit 2 kernel, bit 1 write and bit 0 execute.
- R3: The virtual page is `lk_vaddr[31:13]` and the index is its low 4 bits. A way at that index hits when its VPN equals the page and either its global bit is set or its PID equals `lk_pid`. If several ways hit, the lowest-numbered way is used.
- R4: A translation without a fault returns `res_hit`=1, the entry's PFN on `res_pfn` and `res_vec`=0. `res_perm` bit 0 (read) is always 1, bit 1 is the entry's write bit and bit 2 is its execute bit.
- R5: A miss returns `res_hit`=0 and vector base+0. The base is 4 when `IS_INSN`=1 and 8 when `IS_INSN`=0. On any fault `res_pfn` and `res_perm` are 0.
- R6: After a hit, the protection checks apply in a fixed priority, and the first one that fails sets the vector. The checks are enabled by bits of `lk_chk`: bit 0 kernel, bit 1 write, bit 2 execute, bit 3 valid. `lk_acc` gives the access type: 0 is read, 1 is write, 2 is execute, and 3 is treated as read.
  - Kernel fault, base+2: the kernel check is enabled, the entry's kernel bit is set and `lk_user` is 1.
  - Write fault, base+3: a write, with the write check enabled and the entry's write bit clear.
  - Execute fault, base+3: an execute, with the execute check enabled and the entry's execute bit clear.
  - Invalid fault, base+1: the valid check is enabled and the entry's valid bit is clear.
- R7: The LFSR steps once for each accepted lookup that faults. A step computes the feedback as the parity of (state AND 0x8805), shifts the state right by one and puts the feedback into bit 15. At all other times the LFSR holds its value.
- R8: On a fault, `tlb_sel` becomes the index in bits [3:0] and the way in bits [5:4]. On a miss the way is the LFSR's low 2 bits before the step. On a protection fault it is the matched way. A successful translation leaves `tlb_sel` unchanged.
- R9: On a fault, `mm_cause` bits [7:0] take `lk_pid`, bits [9:8] take the access code (0 read, 1 write, 2 execute) and bits [31:13] take the virtual page. Bits [12:10] keep their value. A successful translation leaves `mm_cause` unchanged.
- R10: `lk_ready` equals `!res_valid || res_ready`. A result that is blocked stays stable, and no lookup is accepted until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way of the slot to write |
| wr_idx | input | 4 | Index of the slot to write |
| wr_hi | input | 32 | Tag word: VPN and PID |
| wr_lo | input | 32 | Data word: PFN and flags |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_vaddr | input | 32 | Virtual address |
| lk_pid | input | 8 | Current process ID |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| lk_user | input | 1 | Access comes from user mode |
| lk_chk | input | 4 | Check enables: kernel, write, execute, valid |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken by the consumer |
| res_hit | output | 1 | Translation succeeded |
| res_pfn | output | 19 | Page frame number |
| res_perm | output | 3 | Permissions: read, write, execute |
| res_vec | output | 4 | Fault vector, 0 on success |
| tlb_sel | output | 6 | Faulting slot: way and index |
| mm_cause | output | 32 | Fault cause: page, access code, PID |

## Verification
Corrupted entry storage appears at the result port in the cycle after the first lookup at that index. It shows up as a wrong PFN, wrong permissions, or a hit changed to a miss. A wrong LFSR state shows up only at the next miss, through the way field of `tlb_sel`. For that reason the bench keeps its own LFSR model and checks the reported way on every miss, including misses that follow hits that must not step the LFSR. A priority or vector error shows up in the same cycle as `res_vec` for each combination of entry flags and check enables. A handshake fault shows up as a changed result, or as a changed cause, while the consumer holds the result back.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W = 19;
  localparam int PID_W = 8;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] pfn;
    logic             glb;
    logic             vld;
    logic             kern;
    logic             wen;
    logic             xen;
  } tlb_ent_t;

  localparam int CHK_KERN = 0;
  localparam int CHK_WR   = 1;
  localparam int CHK_EX   = 2;
  localparam int CHK_VLD  = 3;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic [IDX_W-1:0]      wr_idx,
  input  tlb_ent_t              wr_ent,
  input  logic [IDX_W-1:0]      rd_idx,
  output tlb_ent_t [WAYS-1:0]   rd_ent
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlb_ent_t row [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < SETS; i++) row[i] <= '0;
      end else if (wr_en && wr_way == WAY_W'(g)) begin
        row[wr_idx] <= wr_ent;
      end
    end

    assign rd_ent[g] = row[rd_idx];
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  tlb_ent_t [WAYS-1:0] ent,
  input  logic [VPN_W-1:0]    vpage,
  input  logic [PID_W-1:0]    pid,
  input  acc_e                acc,
  input  logic                user,
  input  logic [3:0]          chk,
  output logic                fault,
  output logic                miss,
  output logic [WAY_W-1:0]    way,
  output logic [1:0]          vec_off,
  output logic [VPN_W-1:0]    pfn,
  output logic [2:0]          perm
);
  tlb_ent_t e;
  logic     any;
  logic     kflt, wflt, xflt, vflt;

  always_comb begin
    any = 1'b0;
    way = '0;
    // scan downwards so the lowest matching way is kept
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (ent[w].vpn == vpage && (ent[w].glb || ent[w].pid == pid)) begin
        any = 1'b1;
        way = WAY_W'(w);
      end
    end
    e    = ent[way];
    kflt = chk[CHK_KERN] && e.kern && user;
    wflt = (acc == ACC_WRITE) && chk[CHK_WR] && !e.wen;
    xflt = (acc == ACC_EXEC) && chk[CHK_EX] && !e.xen;
    vflt = chk[CHK_VLD] && !e.vld;

    fault   = 1'b1;
    vec_off = 2'd0;
    if (!any)      vec_off = 2'd0;
    else if (kflt) vec_off = 2'd2;
    else if (wflt) vec_off = 2'd3;
    else if (xflt) vec_off = 2'd3;
    else if (vflt) vec_off = 2'd1;
    else           fault   = 1'b0;

    miss = !any;
    pfn  = fault ? '0 : e.pfn;
    perm = fault ? 3'b000 : {e.xen, e.wen, 1'b1};
  end
endmodule

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int          W     = 16,
  parameter logic [15:0] SEED  = 16'hCCCC,
  parameter logic [15:0] TAPS  = 16'h8805
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS[W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED[W-1:0];
    else if (step) state <= {fb, state[W-1:1]};
  end

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state)); // R7

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state != '0); // R7
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter bit IS_INSN = 1'b0,
  parameter int WAYS    = 4,
  parameter int SETS    = 16,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int SEL_W  = WAY_W + IDX_W,
  localparam logic [3:0] VEC_BASE = IS_INSN ? 4'd4 : 4'd8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_hi,
  input  logic [31:0]      wr_lo,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [31:0]      lk_vaddr,
  input  logic [7:0]       lk_pid,
  input  logic [1:0]       lk_acc,
  input  logic             lk_user,
  input  logic [3:0]       lk_chk,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_hit,
  output logic [18:0]      res_pfn,
  output logic [2:0]       res_perm,
  output logic [3:0]       res_vec,
  output logic [SEL_W-1:0] tlb_sel,
  output logic [31:0]      mm_cause
);
  tlb_ent_t             wr_ent;
  tlb_ent_t [WAYS-1:0]  rd_ent;
  logic [VPN_W-1:0]     vpage;
  logic [IDX_W-1:0]     idx;
  acc_e                 acc;
  logic                 fault, miss;
  logic [WAY_W-1:0]     m_way, rep_way;
  logic [1:0]           vec_off;
  logic [VPN_W-1:0]     m_pfn;
  logic [2:0]           m_perm;
  logic [15:0]          lfsr;
  logic                 accept;
  logic                 unused_bits;

  assign wr_ent = '{vpn: wr_hi[31:13], pid: wr_hi[7:0], pfn: wr_lo[31:13],
                    glb: wr_lo[4], vld: wr_lo[3], kern: wr_lo[2],
                    wen: wr_lo[1], xen: wr_lo[0]};
  assign unused_bits = ^{wr_hi[12:8], wr_lo[12:5], lk_vaddr[12:0]};

  assign vpage = lk_vaddr[31:13];
  assign idx   = vpage[IDX_W-1:0];
  // the reserved code is treated as a read
  assign acc   = (lk_acc == ACC_RSVD) ? ACC_READ : acc_e'(lk_acc);

  tlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way),
    .wr_idx(wr_idx), .wr_ent(wr_ent), .rd_idx(idx), .rd_ent(rd_ent)
  );

  tlb_match #(.WAYS(WAYS)) u_match (
    .ent(rd_ent), .vpage(vpage), .pid(lk_pid), .acc(acc), .user(lk_user),
    .chk(lk_chk), .fault(fault), .miss(miss), .way(m_way),
    .vec_off(vec_off), .pfn(m_pfn), .perm(m_perm)
  );

  assign lk_ready = !res_valid || res_ready;
  assign accept   = lk_valid && lk_ready;

  tlb_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(accept && fault), .state(lfsr)
  );

  assign rep_way = miss ? lfsr[WAY_W-1:0] : m_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pfn   <= '0;
      res_perm  <= '0;
      res_vec   <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_hit   <= !fault;
      res_pfn   <= m_pfn;
      res_perm  <= m_perm;
      res_vec   <= fault ? VEC_BASE + {2'b00, vec_off} : 4'd0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlb_sel  <= '0;
      mm_cause <= '0;
    end else if (accept && fault) begin
      tlb_sel  <= {rep_way, idx};
      mm_cause <= {vpage, mm_cause[12:10], acc, lk_pid};
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) &&
      $stable(res_pfn) && $stable(res_vec) && $stable(res_perm)); // R10

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && fault) |=> $stable(tlb_sel) && $stable(mm_cause)); // R8

  AST_CAUSE_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> $stable(mm_cause[12:10])); // R9

  AST_FAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_vec[3:2] == VEC_BASE[3:2] &&
      res_pfn == '0 && res_perm == 3'b000); // R5

  AST_SEL_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fault |=> tlb_sel[IDX_W-1:0] == $past(lk_vaddr[13 +: IDX_W])); // R8
endmodule

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic [3:0]  lk_chk = '0;
  logic        res_ready = 1'b1;

  logic        lk_ready, res_valid, res_hit;
  logic [18:0] res_pfn;
  logic [2:0]  res_perm;
  logic [3:0]  res_vec;
  logic [5:0]  tlb_sel;
  logic [31:0] mm_cause;

  logic        i_lk_ready, i_res_valid, i_res_hit;
  logic [18:0] i_res_pfn;
  logic [2:0]  i_res_perm;
  logic [3:0]  i_res_vec;
  logic [5:0]  i_tlb_sel;
  logic [31:0] i_mm_cause;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_lfsr;
  logic [5:0]  m_sel;
  logic [31:0] m_cause;

  always #10 clk = ~clk;

  xlat_tlb #(.IS_INSN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_acc(lk_acc), .lk_user(lk_user),
    .lk_chk(lk_chk), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_pfn(res_pfn), .res_perm(res_perm),
    .res_vec(res_vec), .tlb_sel(tlb_sel), .mm_cause(mm_cause));

  xlat_tlb #(.IS_INSN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .lk_valid(lk_valid), .lk_ready(i_lk_ready),
    .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_acc(lk_acc), .lk_user(lk_user),
    .lk_chk(lk_chk), .res_valid(i_res_valid), .res_ready(res_ready),
    .res_hit(i_res_hit), .res_pfn(i_res_pfn), .res_perm(i_res_perm),
    .res_vec(i_res_vec), .tlb_sel(i_tlb_sel), .mm_cause(i_mm_cause));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {^(s & 16'h8805), s[15:1]};
  endfunction

  function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input logic g,
                                        input logic v, input logic k,
                                        input logic w, input logic x);
    return {pfn, 8'h00, g, v, k, w, x};
  endfunction

  task automatic put(input logic [1:0] way, input logic [18:0] vpn,
                     input logic [7:0] pid, input logic [31:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_idx = vpn[3:0];
    wr_hi = {vpn, 5'b0, pid}; wr_lo = lo;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [18:0] vpn, input logic [7:0] pid,
                      input logic [1:0] acc, input logic user, input logic [3:0] chk);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, 13'h0ABC}; lk_pid = pid;
    lk_acc = acc; lk_user = user; lk_chk = chk;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic exp_hit(input string req, input logic [18:0] pfn, input logic [2:0] perm);
    check({req, " valid"}, {31'b0, res_valid}, 32'd1);
    check({req, " hit"}, {31'b0, res_hit}, 32'd1);
    check({req, " pfn"}, {13'b0, res_pfn}, {13'b0, pfn});
    check({req, " perm"}, {29'b0, res_perm}, {29'b0, perm});
    check({req, " vec"}, {28'b0, res_vec}, 32'd0);
    check({req, " sel kept (R8)"}, {26'b0, tlb_sel}, {26'b0, m_sel});
    check({req, " cause kept (R9)"}, mm_cause, m_cause);
  endtask

  // a fault: way given by caller, code is the access code written to cause
  task automatic exp_fault(input string req, input logic [1:0] way,
                           input logic [18:0] vpn, input logic [7:0] pid,
                           input logic [1:0] code, input logic [3:0] vec);
    m_sel   = {way, vpn[3:0]};
    m_cause = {vpn, 3'b000, code, pid};
    m_lfsr  = lfsr_next(m_lfsr);
    check({req, " hit"}, {31'b0, res_hit}, 32'd0);
    check({req, " vec"}, {28'b0, res_vec}, {28'b0, vec});
    check({req, " insn vec (R5)"}, {28'b0, i_res_vec}, {28'b0, vec - 4'd4});
    check({req, " pfn/perm (R5)"}, {10'b0, res_pfn, res_perm}, 32'd0);
    check({req, " sel (R8)"}, {26'b0, tlb_sel}, {26'b0, m_sel});
    check({req, " cause (R9)"}, mm_cause, m_cause);
  endtask

  task automatic t_reset;
    check("R1 res_valid", {31'b0, res_valid}, 32'd0);
    check("R1 tlb_sel", {26'b0, tlb_sel}, 32'd0);
    check("R1 mm_cause", mm_cause, 32'd0);
  endtask

  task automatic t_first_miss;
    look(19'h00001, 8'h05, 2'd0, 1'b0, 4'hF);
    // R1: seed 0xCCCC gives way 0; R5 vector base 8
    exp_fault("R1 R5 first miss", m_lfsr[1:0], 19'h00001, 8'h05, 2'd0, 4'd8);
  endtask

  task automatic t_basic_hit;
    put(2'd2, 19'h00013, 8'h07, mk_lo(19'h12345, 0, 1, 0, 1, 0));
    look(19'h00013, 8'h07, 2'd0, 1'b1, 4'hF);
    exp_hit("R2 R3 R4 hit rw", 19'h12345, 3'b011);
    // wrong PID misses; the hit before must not have stepped the LFSR (R7)
    look(19'h00013, 8'h08, 2'd1, 1'b0, 4'hF);
    exp_fault("R3 R7 pid miss", m_lfsr[1:0], 19'h00013, 8'h08, 2'd1, 4'd8);
  endtask

  task automatic t_global_prot;
    put(2'd0, 19'h00025, 8'h00, mk_lo(19'h0BEEF, 1, 1, 1, 0, 1));
    look(19'h00025, 8'h55, 2'd2, 1'b0, 4'hF);
    exp_hit("R3 global hit", 19'h0BEEF, 3'b101);
    look(19'h00025, 8'h55, 2'd2, 1'b1, 4'hF);
    exp_fault("R6 kernel", 2'd0, 19'h00025, 8'h55, 2'd2, 4'd10);
    look(19'h00025, 8'h55, 2'd1, 1'b1, 4'hF);
    exp_fault("R6 kernel over write", 2'd0, 19'h00025, 8'h55, 2'd1, 4'd10);
    look(19'h00025, 8'h55, 2'd1, 1'b0, 4'hF);
    exp_fault("R6 write", 2'd0, 19'h00025, 8'h55, 2'd1, 4'd11);
    look(19'h00025, 8'h55, 2'd1, 1'b0, 4'b1101);
    exp_hit("R6 write check off", 19'h0BEEF, 3'b101);
    look(19'h00013, 8'h07, 2'd2, 1'b0, 4'hF);
    exp_fault("R6 exec", 2'd2, 19'h00013, 8'h07, 2'd2, 4'd11);
    look(19'h00013, 8'h07, 2'd3, 1'b0, 4'hF);
    exp_hit("R6 code 3 as read", 19'h12345, 3'b011);
  endtask

  task automatic t_invalid;
    put(2'd3, 19'h00007, 8'h00, mk_lo(19'h00777, 1, 0, 0, 1, 1));
    look(19'h00007, 8'h01, 2'd0, 1'b0, 4'hF);
    exp_fault("R6 invalid", 2'd3, 19'h00007, 8'h01, 2'd0, 4'd9);
    look(19'h00007, 8'h01, 2'd1, 1'b0, 4'b0111);
    exp_hit("R6 valid check off", 19'h00777, 3'b111);
  endtask

  task automatic t_multi;
    put(2'd1, 19'h00013, 8'h07, mk_lo(19'h0AAAA, 0, 1, 0, 1, 0));
    look(19'h00013, 8'h07, 2'd0, 1'b0, 4'hF);
    exp_hit("R3 lowest way", 19'h0AAAA, 3'b011);
    look(19'h00013, 8'h07, 2'd2, 1'b0, 4'hF);
    exp_fault("R8 matched way", 2'd1, 19'h00013, 8'h07, 2'd2, 4'd11);
    for (int k = 0; k < 3; k++) begin
      look(19'h00040 + 19'(k), 8'h09, 2'd0, 1'b0, 4'hF);
      exp_fault("R7 R8 lfsr way", m_lfsr[1:0], 19'h00040 + 19'(k), 8'h09, 2'd0, 4'd8);
    end
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    res_ready = 1'b0;
    look(19'h00025, 8'h55, 2'd0, 1'b0, 4'hF);
    exp_hit("R10 first result", 19'h0BEEF, 3'b101);
    check("R10 ready low", {31'b0, lk_ready}, 32'd0);
    lk_valid = 1'b1; lk_vaddr = {19'h00055, 13'h0}; lk_pid = 8'h02;
    lk_acc = 2'd0; lk_user = 1'b0; lk_chk = 4'hF;
    @(negedge clk);
    @(negedge clk);
    exp_hit("R10 held", 19'h0BEEF, 3'b101);
    res_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    exp_fault("R10 after release", m_lfsr[1:0], 19'h00055, 8'h02, 2'd0, 4'd8);
  endtask

  initial begin
    m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_miss();
    t_basic_hit();
    t_global_prot();
    t_invalid();
    t_multi();
    t_backpressure();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule